// File: doc/BRIEF.md
# Local Memory Region Controller

This block keeps the control state for two tightly-coupled local memories: one that serves instruction fetches and one that serves data accesses. Each memory has one region register that holds a base address, a size code and an enable bit. On every cycle the block compares the current fetch address with the instruction region and the current data address with the data region. It raises a hit flag for each address that falls inside an enabled region. The flag appears in the same cycle as the address.

Two strap inputs set the state at reset. The init strap can bring the instruction region up already enabled at address zero, so boot code that was loaded beforehand runs straight from local memory. The data region always starts disabled. The vector strap selects the reset boot address, either low or high. With the high setting, the first fetch starts outside an instruction region that was enabled at zero. Software reads and writes the two registers through a small coprocessor-style port.

Top module: `tcm_region_ctrl`

## Requirements
- R1: The instruction region register (index 0) resets to base 0, size code INIT_SIZE and enable 1 when `strapInitRam` is high at the last clock of reset. It resets to all zeros when that strap is low.
- R2: The data region register (index 1) always resets to all zeros, whatever the straps are.
- R3: `bootVector` is 0x00000000 when `strapHighVec` is low at the last clock of reset and 0xFFFF0000 when it is high.
- R4: The block samples both straps on every clock while `rstN` is low and keeps the values held at release. Strap changes after release have no effect on the registers or on `bootVector`.
- R5: Register layout: base in bits [31:12], size code in bits [5:2] for a region of 4 KB << code, and enable in bit 0. All other bits read as zero.
- R6: A write needs `regSel=1` and `regWr=1`, and it replaces the whole register selected by `regIdx`. A read needs `regSel=1` and `regWr=0`, and it returns the stored fields at once. With `regSel=0` a write has no effect and `regRdata` is zero.
- R7: A region's hit flag is high in the same cycle as an address when the region is enabled and the address lies in [base, base + size - 1].
- R8: Clearing bit 0 through a read-modify-write disables the region, so it no longer hits. Setting the bit again restores the hit.
- R9: The instruction region compares only `fetchAddr`, and the data region compares only `dataAddr`.
- R10: Decoding ignores base bits below the region size, so a misaligned base behaves as the base rounded down to the size.
- R11: With both straps high, the instruction region covers address 0 but `bootVector` misses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| strapInitRam | input | 1 | Enables the instruction region at base 0 after reset |
| strapHighVec | input | 1 | Selects the high boot address |
| regSel | input | 1 | Register port access strobe |
| regWr | input | 1 | 1 = write, 0 = read |
| regIdx | input | 1 | 0 = instruction region, 1 = data region |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data |
| fetchAddr | input | 32 | Instruction fetch address |
| dataAddr | input | 32 | Data access address |
| instrHit | output | 1 | Fetch address hits the instruction region |
| dataHit | output | 1 | Data address hits the data region |
| bootVector | output | 32 | Reset boot address |

## Verification
The bench builds the block with a 32-bit address, a 4 KB minimum page and a 4-bit size code. With these values the bench can sweep all sixteen region sizes on both regions, from 4 KB to 128 MB. For each size it checks the addresses just outside and just inside both ends of the region. The bench also runs all four strap combinations, with the straps changed after release, plus a misaligned base and the enable toggle done by read-modify-write.

// File: rtl/tcm_region_pkg.sv
package tcm_region_pkg;
  localparam int NUM_REGIONS = 2;
  localparam int IDX_INSTR   = 0;
  localparam int IDX_DATA    = 1;

  typedef struct packed {
    logic loadReset;
    logic initEnable;
    logic wrInstr;
    logic wrData;
    logic rdEnable;
    logic rdSelData;
  } tcmStrobe_t;
endpackage

// File: rtl/tcm_region_ctl.sv
module tcm_region_ctl
  import tcm_region_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapInitRam,
  input  logic              strapHighVec,
  input  logic              regSel,
  input  logic              regWr,
  input  logic              regIdx,
  output tcmStrobe_t        strobe,
  output logic [ADDR_W-1:0] bootVector
);
  localparam logic [ADDR_W-1:0] HIGH_VEC = {{(ADDR_W-16){1'b1}}, 16'h0000};

  logic highVecQ;

  // Vector strap follows the pin for as long as reset is held
  always_ff @(posedge clk) begin
    if (!rstN) highVecQ <= strapHighVec;
  end

  assign bootVector = highVecQ ? HIGH_VEC : '0;

  always_comb begin
    strobe.loadReset  = !rstN;
    strobe.initEnable = strapInitRam;
    strobe.wrInstr    = rstN && regSel && regWr && (regIdx == 1'(IDX_INSTR));
    strobe.wrData     = rstN && regSel && regWr && (regIdx == 1'(IDX_DATA));
    strobe.rdEnable   = regSel && !regWr;
    strobe.rdSelData  = regIdx;
  end

  // R3: vector reflects the strap seen at the final reset edge
  p_vector_select_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (bootVector == ($past(strapHighVec) ? HIGH_VEC : '0)));

  // R4: once out of reset the vector never moves
  p_vector_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(bootVector));
endmodule

// File: rtl/tcm_region_dp.sv
module tcm_region_dp
  import tcm_region_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_LSB  = 12,
  parameter int SIZE_W    = 4,
  parameter int INIT_SIZE = 4
) (
  input  logic              clk,
  input  tcmStrobe_t        strobe,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] dataAddr,
  output logic              instrHit,
  output logic              dataHit
);
  localparam int SIZE_LSB = 2;
  localparam int SHW      = $clog2(ADDR_W) + 1;
  localparam logic [ADDR_W-1:0] BASE_MASK  = {ADDR_W{1'b1}} << PAGE_LSB;
  localparam logic [ADDR_W-1:0] SIZE_MASK  = ADDR_W'((1 << SIZE_W) - 1) << SIZE_LSB;
  localparam logic [ADDR_W-1:0] FIELD_MASK = BASE_MASK | SIZE_MASK | ADDR_W'(1);
  localparam logic [ADDR_W-1:0] INIT_VAL   = (ADDR_W'(INIT_SIZE) << SIZE_LSB) | ADDR_W'(1);

  logic [ADDR_W-1:0] regQ [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] wrVec;
  logic [NUM_REGIONS-1:0] hitVec;
  logic [ADDR_W-1:0] lookupAddr [NUM_REGIONS];

  assign wrVec[IDX_INSTR] = strobe.wrInstr;
  assign wrVec[IDX_DATA]  = strobe.wrData;
  assign lookupAddr[IDX_INSTR] = fetchAddr;
  assign lookupAddr[IDX_DATA]  = dataAddr;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (strobe.loadReset) begin
        regQ[i] <= (i == IDX_INSTR && strobe.initEnable) ? INIT_VAL : '0;
      end else if (wrVec[i]) begin
        regQ[i] <= regWdata & FIELD_MASK;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic [SIZE_W-1:0] sizeCode;
    logic [SHW-1:0]    shAmt;
    logic [ADDR_W-1:0] spanMask;

    assign sizeCode = regQ[g][SIZE_LSB +: SIZE_W];
    assign shAmt    = SHW'(PAGE_LSB) + SHW'(sizeCode);
    assign spanMask = {ADDR_W{1'b1}} << shAmt;
    assign hitVec[g] = regQ[g][0] &&
                       ((lookupAddr[g] & spanMask) == (regQ[g] & spanMask));

    // R5: bits outside the defined fields stay clear
    p_spare_zero_r5: assert property (@(posedge clk) disable iff (strobe.loadReset)
      $past(wrVec[g]) |-> ((regQ[g] & ~FIELD_MASK) == '0));

    // R8: a cleared enable bit never produces a hit
    p_hit_needs_enable_r8: assert property (@(posedge clk) disable iff (strobe.loadReset)
      hitVec[g] |-> regQ[g][0]);
  end

  assign instrHit = hitVec[IDX_INSTR];
  assign dataHit  = hitVec[IDX_DATA];
  assign regRdata = strobe.rdEnable ? regQ[strobe.rdSelData] : '0;

  // R1: instruction enable follows the init strap out of reset
  p_instr_reset_r1: assert property (@(posedge clk) disable iff (strobe.loadReset)
    $past(strobe.loadReset) |-> (regQ[IDX_INSTR][0] == $past(strobe.initEnable)));

  // R2: data region is always disabled out of reset
  p_data_reset_r2: assert property (@(posedge clk) disable iff (strobe.loadReset)
    $past(strobe.loadReset) |-> (regQ[IDX_DATA] == '0));
endmodule

// File: rtl/tcm_region_ctrl.sv
module tcm_region_ctrl
  import tcm_region_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_LSB  = 12,
  parameter int SIZE_W    = 4,
  parameter int INIT_SIZE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapInitRam,
  input  logic              strapHighVec,
  input  logic              regSel,
  input  logic              regWr,
  input  logic              regIdx,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] dataAddr,
  output logic              instrHit,
  output logic              dataHit,
  output logic [ADDR_W-1:0] bootVector
);
  tcmStrobe_t strobe;

  tcm_region_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .strapInitRam(strapInitRam), .strapHighVec(strapHighVec),
    .regSel(regSel), .regWr(regWr), .regIdx(regIdx),
    .strobe(strobe), .bootVector(bootVector)
  );

  tcm_region_dp #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .SIZE_W(SIZE_W), .INIT_SIZE(INIT_SIZE)) u_dp (
    .clk(clk), .strobe(strobe), .regWdata(regWdata), .regRdata(regRdata),
    .fetchAddr(fetchAddr), .dataAddr(dataAddr), .instrHit(instrHit), .dataHit(dataHit)
  );

  // R6: an idle port reads as zero
  p_idle_read_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> (regRdata == '0));
endmodule

// File: tb/sim_tcm_region_ctrl.sv
module sim_tcm_region_ctrl;
  localparam int INIT_SIZE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapInitRam = 1'b0, strapHighVec = 1'b0;
  logic regSel = 1'b0, regWr = 1'b0, regIdx = 1'b0;
  logic [31:0] regWdata = '0, fetchAddr = '0, dataAddr = '0;
  logic [31:0] regRdata, bootVector;
  logic instrHit, dataHit;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tcm_region_ctrl #(.INIT_SIZE(INIT_SIZE)) u0 (
    .clk(clk), .rstN(rstN), .strapInitRam(strapInitRam), .strapHighVec(strapHighVec),
    .regSel(regSel), .regWr(regWr), .regIdx(regIdx), .regWdata(regWdata), .regRdata(regRdata),
    .fetchAddr(fetchAddr), .dataAddr(dataAddr), .instrHit(instrHit), .dataHit(dataHit),
    .bootVector(bootVector)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic init, input logic hv);
    @(negedge clk);
    rstN = 1'b0; strapInitRam = ~init; strapHighVec = ~hv;
    repeat (2) @(negedge clk);
    strapInitRam = init; strapHighVec = hv;
    @(negedge clk);
    rstN = 1'b1; strapInitRam = ~init; strapHighVec = ~hv;  // R4: late change
    @(negedge clk);
  endtask

  task automatic wrReg(input logic idx, input logic [31:0] val, input logic sel = 1'b1);
    @(negedge clk);
    regSel = sel; regWr = 1'b1; regIdx = idx; regWdata = val;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0; regWdata = '0;
  endtask

  task automatic rdReg(input logic idx, output logic [31:0] val);
    regSel = 1'b1; regWr = 1'b0; regIdx = idx;
    #1 val = regRdata;
    regSel = 1'b0;
    #1;
  endtask

  task automatic probe(input logic [31:0] fa, input logic [31:0] da);
    fetchAddr = fa; dataAddr = da;
    #1;
  endtask

  initial begin
    logic [31:0] rv, base, sz, effBase, ext;
    // Reset strap combinations
    for (int c = 0; c < 4; c++) begin
      logic init, hv;
      init = c[0]; hv = c[1];
      doReset(init, hv);
      rdReg(1'b0, rv);
      chk(init ? "R1 init high" : "R1 init low", rv, init ? ((32'(INIT_SIZE) << 2) | 32'h1) : 32'h0);
      rdReg(1'b1, rv);
      chk("R2 data reset", rv, 32'h0);
      chk("R3 boot vector", bootVector, hv ? 32'hFFFF0000 : 32'h0);
      repeat (3) @(negedge clk);
      chk("R4 vector held", bootVector, hv ? 32'hFFFF0000 : 32'h0);
      rdReg(1'b0, rv);
      chk("R4 instr held", {31'b0, rv[0]}, {31'b0, init});
      probe(32'h0, 32'h0);
      chk("R1 hit at zero", {31'b0, instrHit}, {31'b0, init});
      chk("R2 no data hit", {31'b0, dataHit}, 32'h0);
      if (init && hv) begin
        probe(bootVector, 32'h0);
        chk("R11 boot misses region", {31'b0, instrHit}, 32'h0);
      end
    end

    // R5/R6 layout, masking, idle write and idle read
    wrReg(1'b1, 32'hFFFF_FFFF);
    rdReg(1'b1, rv);
    chk("R5 spare bits zero", rv, 32'hFFFF_F03D);
    wrReg(1'b1, 32'h1234_5008, 1'b0);
    rdReg(1'b1, rv);
    chk("R6 unselected write ignored", rv, 32'hFFFF_F03D);
    chk("R6 idle read zero", regRdata, 32'h0);
    wrReg(1'b1, 32'h0);

    // Full size sweep on both regions, boundary addresses
    for (int code = 0; code < 16; code++) begin
      for (int reg_i = 0; reg_i < 2; reg_i++) begin
        logic [31:0] a [4];
        base = 32'h4000_0000;
        sz = 32'h1000 << code;
        wrReg(1'b0, 32'h0);
        wrReg(1'b1, 32'h0);
        wrReg(reg_i[0], base | (32'(code) << 2) | 32'h1);
        a[0] = base - 1; a[1] = base; a[2] = base + sz - 1; a[3] = base + sz;
        for (int k = 0; k < 4; k++) begin
          logic e;
          e = (a[k] >= base) && (a[k] < base + sz);
          probe(a[k], a[k]);
          if (reg_i == 0) begin
            chk("R7 instr boundary", {31'b0, instrHit}, {31'b0, e});
            chk("R9 data ignores instr region", {31'b0, dataHit}, 32'h0);
          end else begin
            chk("R7 data boundary", {31'b0, dataHit}, {31'b0, e});
            chk("R9 instr ignores data region", {31'b0, instrHit}, 32'h0);
          end
        end
      end
    end

    // R10 misaligned base
    base = 32'h4000_5000; sz = 32'h4000; effBase = base & ~(sz - 1);
    wrReg(1'b1, base | (32'd2 << 2) | 32'h1);
    for (int k = 0; k < 4; k++) begin
      logic e;
      ext = (k == 0) ? effBase - 1 : (k == 1) ? effBase : (k == 2) ? effBase + sz - 1 : effBase + sz;
      e = (k == 1) || (k == 2);
      probe(32'h0, ext);
      chk("R10 misaligned base", {31'b0, dataHit}, {31'b0, e});
    end

    // R8 read-modify-write enable toggle on instruction region
    wrReg(1'b0, 32'h0800_0000 | (32'd1 << 2) | 32'h1);
    @(negedge clk);
    rdReg(1'b0, rv);
    wrReg(1'b0, rv & ~32'h1);
    probe(32'h0800_1000, 32'h0);
    chk("R8 disabled no hit", {31'b0, instrHit}, 32'h0);
    rdReg(1'b0, rv);
    chk("R8 fields kept", rv, 32'h0800_0004);
    wrReg(1'b0, rv | 32'h1);
    probe(32'h0800_1FFF, 32'h0);
    chk("R8 re-enabled hit", {31'b0, instrHit}, 32'h1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule